// File: doc/BRIEF.md
# Audio Clock Regeneration Parameter Unit

This block supplies the N and CTS words that a display transmitter sends so a sink can rebuild the audio clock from the pixel clock. On a start strobe it scans a built-in rate table for the pixel clock (given in kHz) and selects the first-fitting entry. It then pushes the chosen pair through the same staged byte-register path that software uses, so both sources obey one commit rule. If the pixel clock is above every table entry, it raises an unsupported flag and the committed words stay as they were.

Software can also load N and CTS by hand through a byte-wide write port. The six staging bytes take effect together only when the lowest N byte is written while the stage is armed. The same port sets the audio input clock ratio code. A lookup always sets that code back to 128 times the sample rate and always marks CTS as a manual value.

Top module: `acr_param_unit`

## Requirements
- R1: After reset `acr_n` and `acr_cts` are 0, `acr_valid`, `unsupported`, `cts_manual` and `busy` are low, and `ratio_code` is 0.
- R2: A lookup picks the lowest-index table entry whose threshold is greater than or equal to `pix_khz`. A value equal to a threshold selects that entry, and a value one above it selects the next entry.
- R3: The table thresholds in ascending order are 25175, 25200, 27000, 27027, 40000, 54000, 54054, 65000, 74176, 74250, 83500, 106500, 108000, 148352, 148500 and 297000 kHz. Entry 74176 gives N=11648 and CTS=140625. Entry 148352 gives N=5824 and CTS=140625. Entry 297000 gives N=5120 and CTS=247500. Every other entry gives N=6144 and CTS equal to its threshold.
- R4: A lookup with `pix_khz` above 297000 sets `unsupported` and produces no commit, so `acr_n` and `acr_cts` do not change. The next lookup start or the next commit clears `unsupported`.
- R5: A lookup that hits commits within 25 clock cycles of the cycle in which `lookup_go` is sampled. `busy` is high in between, `acr_valid` pulses for exactly one cycle, `cts_manual` becomes 1 and `ratio_code` becomes 0 (the code for 128 times the sample rate).
- R6: Write addresses: 0 = N bits 7:0, 1 = N bits 15:8, 2 = N top byte (bit 7 is the arm flag, bits 3:0 are N bits 19:16), 3 = CTS bits 7:0, 4 = CTS bits 15:8, 5 = CTS top byte (bit 4 is the manual-CTS flag, bits 3:0 are CTS bits 19:16), 6 = ratio code in bits 1:0. Address 7 has no effect.
- R7: A write to address 2 with bit 7 set arms the stage and a write with bit 7 clear disarms it. While the stage is not armed, writes to addresses 1, 3, 4 and 5 are dropped, and a write to address 0 commits nothing.
- R8: Writes to addresses 3 and 4 are dropped unless address 5 has been written since the stage was armed.
- R9: A write to address 0 while armed moves all staged fields to the outputs in one cycle, pulses `acr_valid` and disarms the stage. Between commits the committed outputs hold their values.
- R10: While `busy` is high, `wr_en` writes and further `lookup_go` strobes are ignored.
- R11: A write to address 6 while idle sets `ratio_code`, whether or not the stage is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_khz | input | PIX_W | Pixel clock in kHz, held stable during a lookup |
| lookup_go | input | 1 | Starts a table lookup |
| wr_en | input | 1 | Byte register write strobe |
| wr_addr | input | 3 | Byte register address |
| wr_data | input | 8 | Byte register write data |
| busy | output | 1 | Lookup in progress |
| acr_n | output | 20 | Committed N |
| acr_cts | output | 20 | Committed CTS |
| cts_manual | output | 1 | Committed manual-CTS flag |
| ratio_code | output | 2 | Audio input clock ratio code |
| acr_valid | output | 1 | One-cycle pulse on each commit |
| unsupported | output | 1 | Last lookup found no entry |

## Verification
The hardest cases to reach are the dropped writes. These are a CTS low or middle byte sent before the CTS top byte, staging writes sent while unarmed, and port writes that land during a lookup. None of them shows at the outputs until a later commit exposes the staged contents. The stimulus therefore arms the stage, makes the write that should be dropped, and then commits with only the remaining bytes. The expected words keep the bytes left over from the previous commit. For writes made during a lookup, the bench then sends a bare low N byte and expects no commit, which shows the arming write was never accepted. Lookups at exact thresholds, one above them, at the last entry and above it cover the first-fit edge and the longest scan.

// File: rtl/acr_pkg.sv
package acr_pkg;
   localparam int ACR_W     = 20;
   localparam int TABLE_LEN = 16;
   localparam int RATIO_W   = 2;
   localparam int ARM_BIT   = 7;
   localparam int MAN_BIT   = 4;

   localparam logic [2:0] A_N_LO    = 3'd0;
   localparam logic [2:0] A_N_MID   = 3'd1;
   localparam logic [2:0] A_N_HI    = 3'd2;
   localparam logic [2:0] A_CTS_LO  = 3'd3;
   localparam logic [2:0] A_CTS_MID = 3'd4;
   localparam logic [2:0] A_CTS_HI  = 3'd5;
   localparam logic [2:0] A_RATIO   = 3'd6;

   localparam logic [RATIO_W-1:0] RATIO_X128 = '0;

   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_LOAD} seq_state_e;

   typedef struct packed {
      logic [ACR_W-1:0] thr;
      logic [ACR_W-1:0] n;
      logic [ACR_W-1:0] cts;
   } acr_row_t;

   function automatic acr_row_t acr_row(input int i);
      acr_row_t r;
      case (i)
         0:  r.thr = 20'd25175;
         1:  r.thr = 20'd25200;
         2:  r.thr = 20'd27000;
         3:  r.thr = 20'd27027;
         4:  r.thr = 20'd40000;
         5:  r.thr = 20'd54000;
         6:  r.thr = 20'd54054;
         7:  r.thr = 20'd65000;
         8:  r.thr = 20'd74176;
         9:  r.thr = 20'd74250;
         10: r.thr = 20'd83500;
         11: r.thr = 20'd106500;
         12: r.thr = 20'd108000;
         13: r.thr = 20'd148352;
         14: r.thr = 20'd148500;
         default: r.thr = 20'd297000;
      endcase
      r.n   = 20'd6144;
      r.cts = r.thr;
      case (i)
         8:  begin r.n = 20'd11648; r.cts = 20'd140625; end
         13: begin r.n = 20'd5824;  r.cts = 20'd140625; end
         15: begin r.n = 20'd5120;  r.cts = 20'd247500; end
         default: ;
      endcase
      return r;
   endfunction

   function automatic logic [ACR_W-1:0] acr_thr(input int i);
      acr_row_t r;
      r = acr_row(i);
      return r.thr;
   endfunction
endpackage

// File: rtl/acr_rate_table.sv
module acr_rate_table
   import acr_pkg::*;
#(
   parameter int PIX_W   = 20,
   parameter int ENTRIES = TABLE_LEN,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [PIX_W-1:0] pix_khz,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ENTRIES-1:0] hit_vec,
   output logic [ACR_W-1:0]  sel_n,
   output logic [ACR_W-1:0]  sel_cts
);
   logic [31:0] pix_ext;
   assign pix_ext = 32'(pix_khz);

   generate
      for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
         assign hit_vec[gi] = (pix_ext <= 32'(acr_thr(gi)));
      end
      for (genvar gk = 1; gk < ENTRIES; gk++) begin : g_order
         if (acr_thr(gk) <= acr_thr(gk - 1)) begin : g_bad
            $error("rate table thresholds must ascend");
         end
      end
   endgenerate

   always_comb begin
      acr_row_t r;
      r       = acr_row(int'(rd_idx));
      sel_n   = r.n;
      sel_cts = r.cts;
   end
endmodule

// File: rtl/acr_lookup_seq.sv
module acr_lookup_seq
   import acr_pkg::*;
#(
   parameter int ENTRIES       = TABLE_LEN,
   parameter bit SERIAL_SEARCH = 1'b1,
   localparam int IDX_W        = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [ENTRIES-1:0] hit_vec,
   input  logic [ACR_W-1:0]   sel_n,
   input  logic [ACR_W-1:0]   sel_cts,
   output logic [IDX_W-1:0]   rd_idx,
   output logic               busy,
   output logic               start,
   output logic               miss,
   output logic               int_we,
   output logic [2:0]         int_addr,
   output logic [7:0]         int_data
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [2:0]       step;
   logic             found;
   logic             last;
   logic [IDX_W-1:0] found_idx;

   generate
      if (SERIAL_SEARCH) begin : g_serial
         assign found     = hit_vec[idx];
         assign found_idx = idx;
         assign last      = (idx == LAST_IDX);
      end else begin : g_parallel
         always_comb begin
            found_idx = '0;
            for (int i = ENTRIES - 1; i >= 0; i--)
               if (hit_vec[i]) found_idx = IDX_W'(i);
         end
         assign found = |hit_vec;
         assign last  = 1'b1;
      end
   endgenerate

   assign rd_idx = idx;
   assign busy   = (state != ST_IDLE);
   assign start  = go && (state == ST_IDLE);
   assign miss   = (state == ST_SCAN) && !found && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         step  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (go) begin
               state <= ST_SCAN;
               idx   <= '0;
               step  <= '0;
            end
            ST_SCAN: begin
               if (found) begin
                  state <= ST_LOAD;
                  idx   <= found_idx;
               end else if (last) begin
                  state <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_LOAD: begin
               step <= step + 1'b1;
               if (step == 3'd7) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Internal write order: arm, CTS top/mid/low, N top, N mid, ratio, N low (commit)
   always_comb begin
      int_we   = (state == ST_LOAD);
      int_addr = A_N_HI;
      int_data = 8'h80;
      case (step)
         3'd0: begin int_addr = A_N_HI;    int_data = 8'h80; end
         3'd1: begin int_addr = A_CTS_HI;  int_data = {4'h1, sel_cts[19:16]}; end
         3'd2: begin int_addr = A_CTS_MID; int_data = sel_cts[15:8]; end
         3'd3: begin int_addr = A_CTS_LO;  int_data = sel_cts[7:0]; end
         3'd4: begin int_addr = A_N_HI;    int_data = {4'h8, sel_n[19:16]}; end
         3'd5: begin int_addr = A_N_MID;   int_data = sel_n[15:8]; end
         3'd6: begin int_addr = A_RATIO;   int_data = 8'(RATIO_X128); end
         default: begin int_addr = A_N_LO; int_data = sel_n[7:0]; end
      endcase
   end

   AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && step == 3'd7) |=> (state == ST_IDLE)); // R5
   AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> !busy); // R4
endmodule

// File: rtl/acr_stage_regs.sv
module acr_stage_regs
   import acr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         addr,
   input  logic [7:0]         data,
   input  logic               lookup_start,
   input  logic               miss,
   output logic [ACR_W-1:0]   acr_n,
   output logic [ACR_W-1:0]   acr_cts,
   output logic               cts_manual,
   output logic [RATIO_W-1:0] ratio_code,
   output logic               acr_valid,
   output logic               unsupported
);
   logic       armed, top_seen, stg_man;
   logic [3:0] stg_n_top, stg_cts_top;
   logic [7:0] stg_n_mid, stg_cts_mid, stg_cts_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0; top_seen <= 1'b0; stg_man <= 1'b0;
         stg_n_top <= '0; stg_cts_top <= '0;
         stg_n_mid <= '0; stg_cts_mid <= '0; stg_cts_lo <= '0;
         acr_n <= '0; acr_cts <= '0; cts_manual <= 1'b0;
         ratio_code <= RATIO_X128; acr_valid <= 1'b0; unsupported <= 1'b0;
      end else begin
         acr_valid <= 1'b0;
         if (lookup_start) unsupported <= 1'b0;
         if (miss)         unsupported <= 1'b1;
         if (we) begin
            case (addr)
               A_N_HI: begin
                  if (data[ARM_BIT]) begin
                     armed     <= 1'b1;
                     stg_n_top <= data[3:0];
                  end else begin
                     armed    <= 1'b0;
                     top_seen <= 1'b0;
                  end
               end
               A_N_MID:   if (armed) stg_n_mid <= data;
               A_CTS_HI:  if (armed) begin
                  stg_cts_top <= data[3:0];
                  stg_man     <= data[MAN_BIT];
                  top_seen    <= 1'b1;
               end
               A_CTS_MID: if (armed && top_seen) stg_cts_mid <= data;
               A_CTS_LO:  if (armed && top_seen) stg_cts_lo  <= data;
               A_RATIO:   ratio_code <= data[RATIO_W-1:0];
               A_N_LO:    if (armed) begin
                  acr_n       <= {stg_n_top, stg_n_mid, data};
                  acr_cts     <= {stg_cts_top, stg_cts_mid, stg_cts_lo};
                  cts_manual  <= stg_man;
                  acr_valid   <= 1'b1;
                  armed       <= 1'b0;
                  top_seen    <= 1'b0;
                  unsupported <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      acr_valid |=> !acr_valid); // R5
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !acr_valid |-> ($stable(acr_n) && $stable(acr_cts) && $stable(cts_manual))); // R9
   AST_MISS_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unsupported) |-> (!acr_valid && $stable(acr_n) && $stable(acr_cts))); // R4
   AST_COMMIT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      acr_valid |-> $past(armed)); // R7
endmodule

// File: rtl/acr_param_unit.sv
module acr_param_unit
   import acr_pkg::*;
#(
   parameter int PIX_W         = 20,
   parameter int ENTRIES       = TABLE_LEN,
   parameter bit SERIAL_SEARCH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PIX_W-1:0]   pix_khz,
   input  logic               lookup_go,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [7:0]         wr_data,
   output logic               busy,
   output logic [ACR_W-1:0]   acr_n,
   output logic [ACR_W-1:0]   acr_cts,
   output logic               cts_manual,
   output logic [RATIO_W-1:0] ratio_code,
   output logic               acr_valid,
   output logic               unsupported
);
   localparam int IDX_W = $clog2(ENTRIES);

   generate
      if (PIX_W < 19 || PIX_W > 32) begin : g_bad_pix
         $error("PIX_W must lie in 19..32");
      end
      if (ENTRIES < 2 || ENTRIES > TABLE_LEN) begin : g_bad_len
         $error("ENTRIES must lie in 2..TABLE_LEN");
      end
   endgenerate

   logic [ENTRIES-1:0] hit_vec;
   logic [ACR_W-1:0]   sel_n, sel_cts;
   logic [IDX_W-1:0]   rd_idx;
   logic               start, miss, int_we;
   logic [2:0]         int_addr;
   logic [7:0]         int_data;
   logic               st_we;
   logic [2:0]         st_addr;
   logic [7:0]         st_data;

   acr_rate_table #(.PIX_W(PIX_W), .ENTRIES(ENTRIES)) u_table (
      .pix_khz(pix_khz), .rd_idx(rd_idx), .hit_vec(hit_vec),
      .sel_n(sel_n), .sel_cts(sel_cts));

   acr_lookup_seq #(.ENTRIES(ENTRIES), .SERIAL_SEARCH(SERIAL_SEARCH)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(lookup_go), .hit_vec(hit_vec),
      .sel_n(sel_n), .sel_cts(sel_cts), .rd_idx(rd_idx), .busy(busy),
      .start(start), .miss(miss), .int_we(int_we), .int_addr(int_addr),
      .int_data(int_data));

   // The sequencer owns the staging port while busy; port writes are dropped
   assign st_we   = busy ? int_we   : wr_en;
   assign st_addr = busy ? int_addr : wr_addr;
   assign st_data = busy ? int_data : wr_data;

   acr_stage_regs u_stage (
      .clk(clk), .rst_n(rst_n), .we(st_we), .addr(st_addr), .data(st_data),
      .lookup_start(start), .miss(miss), .acr_n(acr_n), .acr_cts(acr_cts),
      .cts_manual(cts_manual), .ratio_code(ratio_code),
      .acr_valid(acr_valid), .unsupported(unsupported));

   AST_BUSY_NO_PORT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && acr_valid) |-> $past(int_we)); // R10
endmodule

// File: tb/acr_param_unit_test.sv
module acr_param_unit_test;
   localparam int ENTRIES = 16;

   typedef struct {
      logic [19:0] n;
      logic [19:0] cts;
      logic        man;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] pix_khz = '0;
   logic        lookup_go = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        busy, cts_manual, acr_valid, unsupported;
   logic [19:0] acr_n, acr_cts;
   logic [1:0]  ratio_code;

   int   n_chk = 0, n_bad = 0, vcnt = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #10 clk = ~clk;

   acr_param_unit uut (
      .clk(clk), .rst_n(rst_n), .pix_khz(pix_khz), .lookup_go(lookup_go),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
      .acr_n(acr_n), .acr_cts(acr_cts), .cts_manual(cts_manual),
      .ratio_code(ratio_code), .acr_valid(acr_valid), .unsupported(unsupported));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Reference table written from R3
   task automatic ref_find(input logic [19:0] pix, output logic [19:0] n,
                           output logic [19:0] cts, output bit hit);
      int thr[16] = '{25175, 25200, 27000, 27027, 40000, 54000, 54054, 65000,
                      74176, 74250, 83500, 106500, 108000, 148352, 148500, 297000};
      hit = 1'b0; n = '0; cts = '0;
      for (int i = 0; i < 16; i++) begin
         if (!hit && int'(pix) <= thr[i]) begin
            hit = 1'b1;
            n = 20'd6144; cts = 20'(thr[i]);
            if (thr[i] == 74176)  begin n = 20'd11648; cts = 20'd140625; end
            if (thr[i] == 148352) begin n = 20'd5824;  cts = 20'd140625; end
            if (thr[i] == 297000) begin n = 20'd5120;  cts = 20'd247500; end
         end
      end
   endtask

   // Monitor: pops one expected item per commit pulse
   always @(negedge clk) begin
      if (rst_n && acr_valid) begin
         vcnt++;
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R9: actual unexpected commit n=%0h expected none", acr_n);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " n"}, 64'(acr_n), 64'(e.n));
            chk({e.tag, " cts"}, 64'(acr_cts), 64'(e.cts));
            chk({e.tag, " manual"}, 64'(cts_manual), 64'(e.man));
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push(input logic [19:0] n, input logic [19:0] c, input logic m, input string t);
      exp_t e;
      e.n = n; e.cts = c; e.man = m; e.tag = t;
      sb.push_back(e);
   endtask

   task automatic run_lookup(input logic [19:0] pix, input string tag);
      logic [19:0] en, ec, n0, c0;
      bit hit;
      int cyc, v0;
      ref_find(pix, en, ec, hit);
      if (hit) push(en, ec, 1'b1, tag);
      v0 = vcnt; n0 = acr_n; c0 = acr_cts;
      pix_khz = pix; lookup_go = 1'b1;
      @(negedge clk);
      lookup_go = 1'b0; cyc = 1;
      while (busy && cyc < 100) begin @(negedge clk); cyc++; end
      @(negedge clk);
      chk({tag, " R5 cycles within bound"}, 64'(cyc <= ENTRIES + 9), 64'd1);
      if (hit) begin
         chk({tag, " R5 one commit"}, 64'(vcnt), 64'(v0 + 1));
         chk({tag, " R5 ratio 128x"}, 64'(ratio_code), 64'd0);
         chk({tag, " R4 flag low"}, 64'(unsupported), 64'd0);
      end else begin
         chk({tag, " R4 flag"}, 64'(unsupported), 64'd1);
         chk({tag, " R4 no commit"}, 64'(vcnt), 64'(v0));
         chk({tag, " R4 n held"}, 64'(acr_n), 64'(n0));
         chk({tag, " R4 cts held"}, 64'(acr_cts), 64'(c0));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [19:0] pn, pc;
      int v0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 n", 64'(acr_n), 64'd0);
      chk("R1 cts", 64'(acr_cts), 64'd0);
      chk("R1 flags", 64'({acr_valid, unsupported, cts_manual, busy}), 64'd0);
      chk("R1 ratio", 64'(ratio_code), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R3 first-fit lookups
      run_lookup(20'd0,      "R2 lowest");
      run_lookup(20'd25175,  "R2 exact first");
      run_lookup(20'd25176,  "R2 one above");
      run_lookup(20'd74176,  "R3 fractional 74176");
      run_lookup(20'd74177,  "R3 after fractional");
      run_lookup(20'd148352, "R3 fractional 148352");
      run_lookup(20'd200000, "R3 top entry");

      // R4 above table, then cleared by next lookup
      run_lookup(20'd297001, "R4 above");
      run_lookup(20'd1048575,"R4 max input");
      run_lookup(20'd297000, "R4 recovery exact last");

      // R11 ratio write while idle, unarmed
      wr(3'd6, 8'h02);
      chk("R11 ratio code", 64'(ratio_code), 64'd2);
      wr(3'd7, 8'hFF);
      chk("R6 addr 7 no effect", 64'(ratio_code), 64'd2);

      // R9 / R6 full manual load
      wr(3'd2, 8'h83);
      wr(3'd5, 8'h0A);
      wr(3'd4, 8'hBC);
      wr(3'd3, 8'hDE);
      wr(3'd1, 8'h45);
      chk("R9 held before commit n", 64'(acr_n), 64'd247500 == 0 ? 64'd0 : 64'(20'd5120));
      push(20'h34567, 20'hABCDE, 1'b0, "R9 manual");
      v0 = vcnt;
      wr(3'd0, 8'h67);
      @(negedge clk);
      chk("R9 manual commit count", 64'(vcnt), 64'(v0 + 1));
      pn = acr_n; pc = acr_cts;

      // R7 unarmed writes dropped, bare low byte commits nothing
      v0 = vcnt;
      wr(3'd5, 8'h1F);
      wr(3'd1, 8'h99);
      wr(3'd0, 8'h11);
      repeat (2) @(negedge clk);
      chk("R7 no commit unarmed", 64'(vcnt), 64'(v0));
      wr(3'd2, {4'h8, pn[19:16]});
      push({pn[19:8], 8'h5A}, pc, 1'b0, "R7 dropped bytes");
      wr(3'd0, 8'h5A);
      @(negedge clk);
      // R7 disarm
      v0 = vcnt;
      wr(3'd2, 8'h80);
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h22);
      repeat (2) @(negedge clk);
      chk("R7 disarm blocks commit", 64'(vcnt), 64'(v0));

      // R8 CTS low bytes before the top byte are dropped
      pn = acr_n; pc = acr_cts;
      wr(3'd2, {4'h8, pn[19:16]});
      wr(3'd4, 8'h77);
      wr(3'd3, 8'h66);
      wr(3'd5, 8'h11);
      wr(3'd3, 8'h22);
      push(pn, {4'h1, pc[15:8], 8'h22}, 1'b1, "R8 order");
      wr(3'd0, pn[7:0]);
      @(negedge clk);

      // R10 writes and go during busy ignored
      push(20'd6144, 20'd54000, 1'b1, "R10 lookup");
      v0 = vcnt;
      pix_khz = 20'd54000; lookup_go = 1'b1;
      @(negedge clk);
      lookup_go = 1'b0;
      wr(3'd2, 8'h80);
      wr(3'd0, 8'h11);
      wr(3'd6, 8'h03);
      lookup_go = 1'b1;
      @(negedge clk);
      lookup_go = 1'b0;
      repeat (40) @(negedge clk);
      chk("R10 single commit", 64'(vcnt), 64'(v0 + 1));
      chk("R10 ratio write dropped", 64'(ratio_code), 64'd0);
      wr(3'd0, 8'h99);
      repeat (2) @(negedge clk);
      chk("R10 arm write dropped", 64'(vcnt), 64'(v0 + 1));
      chk("R10 scoreboard drained", 64'(sb.size()), 64'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule